// File: doc/BRIEF.md
# Nested-Loop Matrix Index Scheduler

This block walks a three-deep loop nest and, on every step, hands the issue logic three element offsets for an in-place matrix multiply-accumulate: one into the accumulator matrix C, one into the left operand A and one into the right operand B. The issue logic reads the three registers at those offsets and issues one scalar multiply-accumulate into the C element. The arithmetic, the register file and instruction decode all live outside this block.

Software sets the three loop extents (rows of A, the shared inner dimension, columns of B), a nesting order code and a per-dimension reverse mask, then pulses `start`. The scheduler presents a triple with `valid` high and holds it until `step` is seen, so a stalled back end simply keeps `step` low. After the final triple is consumed, `done` pulses for one cycle and the block goes idle. A configuration that is empty, names an undefined order, or needs more than 127 steps is refused with a one-cycle `cfg_err` and nothing is issued.

Top module: `mm_idx_sched`

## Requirements
- R1: While `valid` is high with row index i, inner index v and column index j, the outputs are `off_c` = i*cols + j, `off_a` = i*inner + v and `off_b` = v*cols + j.
- R2: With order code 0 the row loop is outermost, the inner loop is in the middle and the column loop is innermost, so with cols > 1 two consecutive triples never carry the same `off_c`.
- R3: `cfg_order` selects the nesting, outermost to innermost: 0 = i,v,j; 1 = i,j,v; 2 = v,i,j; 3 = v,j,i; 4 = j,i,v; 5 = j,v,i.
- R4: `cfg_rev` bit 0 reverses i, bit 1 reverses v, bit 2 reverses j; a reversed index starts at extent-1 and counts down to 0, each independently.
- R5: Any extent from 1 to 127 is accepted, with no power-of-two restriction, and exactly rows*inner*cols triples are issued per schedule, up to 127.
- R6: A `start` in idle with any zero extent, a product above 127 or an order code of 6 or 7 raises `cfg_err` for exactly the next cycle and issues no triple.
- R7: `valid` rises in the cycle after an accepted `start`; `done` is high for exactly the one cycle after the final triple is consumed, with `valid` low, and the block then idles.
- R8: While `valid` is high and `step` is low, the triple and `valid` hold unchanged.
- R9: `start` while a schedule is running is ignored.
- R10: Under reset `valid`, `done` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a schedule with the present configuration (idle only) |
| step | input | 1 | Consume the presented triple and advance |
| cfg_rows | input | 7 | Rows of A and C (i extent) |
| cfg_inner | input | 7 | Shared inner dimension (v extent) |
| cfg_cols | input | 7 | Columns of B and C (j extent) |
| cfg_order | input | 3 | Nesting order code |
| cfg_rev | input | 3 | Per-dimension reverse mask |
| valid | output | 1 | A triple is presented |
| off_c | output | 7 | Accumulator offset |
| off_a | output | 7 | Left operand offset |
| off_b | output | 7 | Right operand offset |
| done | output | 1 | One-cycle end-of-schedule pulse |
| cfg_err | output | 1 | One-cycle configuration refusal |

## Verification
The bench aims at the carry between loop levels under every nesting code with mixed reverse masks, where a wrong rank decode would repeat or skip index combinations and give a wrong offset sequence. Degenerate shapes (1x1x1, and 127 along one dimension) expose off-by-one terminal counts that would issue one triple too many or stop one early. The refusal boundary at 128 steps, a zero extent and an undefined order code check that a faulty limit compare would start a schedule it must refuse. Stalls and a stray `start` mid-run check that a design advancing without `step` or restarting would break the held triple.

// File: rtl/mm_sched_pkg.sv
// Shared definitions for the matrix index scheduler.
// Assumes three loop dimensions: 0 = row (i), 1 = inner (v), 2 = column (j).
package mm_sched_pkg;

    localparam int NDIM = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } sched_state_t;

    // Nesting rank per dimension, packed {rank_j, rank_v, rank_i};
    // rank 0 is outermost, rank 2 innermost. Codes 6 and 7 are refused elsewhere.
    function automatic logic [5:0] order_rank(input logic [2:0] code);
        logic [5:0] r;
        case (code)
            3'd1:    r = {2'd1, 2'd2, 2'd0};
            3'd2:    r = {2'd2, 2'd0, 2'd1};
            3'd3:    r = {2'd1, 2'd0, 2'd2};
            3'd4:    r = {2'd0, 2'd2, 2'd1};
            3'd5:    r = {2'd0, 2'd1, 2'd2};
            default: r = {2'd2, 2'd1, 2'd0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mm_cfg_check.sv
// Configuration validator: decides whether a requested schedule may start.
// Assumes the extents are unsigned; purely combinational.
module mm_cfg_check #(
    parameter int MAX_STEPS = 127,
    parameter int DIM_W     = 7
) (
    input  logic [DIM_W-1:0] ext_i,
    input  logic [DIM_W-1:0] ext_v,
    input  logic [DIM_W-1:0] ext_j,
    input  logic [2:0]       order,
    output logic             cfg_ok
);
    localparam int PROD_W = 3 * DIM_W;

    logic [PROD_W-1:0] total;

    // Total step count of the requested nest.
    always_comb begin
        total = PROD_W'(ext_i) * PROD_W'(ext_v) * PROD_W'(ext_j);
    end

    // Accept only non-empty, defined, bounded schedules.
    always_comb begin
        cfg_ok = (ext_i != '0) && (ext_v != '0) && (ext_j != '0)
              && (order <= 3'd5)
              && (total <= PROD_W'(MAX_STEPS));
    end

endmodule

// File: rtl/mm_dim_counter.sv
// One loop dimension: an up or down counter over 0..extent-1.
// Assumes extent_in is non-zero whenever load is asserted.
module mm_dim_counter #(
    parameter int DIM_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic [DIM_W-1:0] extent_in,
    input  logic             rev_in,
    output logic [DIM_W-1:0] cnt,
    output logic [DIM_W-1:0] extent_q,
    output logic             at_last
);
    logic rev_q;

    // Terminal value depends on the counting direction.
    always_comb begin
        at_last = rev_q ? (cnt == '0) : (cnt == extent_q - DIM_W'(1));
    end

    // Latch extent/direction on load; step or wrap on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            extent_q <= '0;
            rev_q    <= 1'b0;
        end else if (load) begin
            extent_q <= extent_in;
            rev_q    <= rev_in;
            cnt      <= rev_in ? extent_in - DIM_W'(1) : '0;
        end else if (adv) begin
            if (at_last)
                cnt <= rev_q ? extent_q - DIM_W'(1) : '0;
            else if (rev_q)
                cnt <= cnt - DIM_W'(1);
            else
                cnt <= cnt + DIM_W'(1);
        end
    end

endmodule

// File: rtl/mm_offset_gen.sv
// Row-major offset arithmetic for C[i][j], A[i][v] and B[v][j].
// Assumes every offset fits OFF_W because the schedule size is bounded.
module mm_offset_gen #(
    parameter int DIM_W = 7,
    parameter int OFF_W = 7
) (
    input  logic [DIM_W-1:0] idx_i,
    input  logic [DIM_W-1:0] idx_v,
    input  logic [DIM_W-1:0] idx_j,
    input  logic [DIM_W-1:0] n_inner,
    input  logic [DIM_W-1:0] n_cols,
    output logic [OFF_W-1:0] off_c,
    output logic [OFF_W-1:0] off_a,
    output logic [OFF_W-1:0] off_b
);
    localparam int MUL_W = 2 * DIM_W;

    // One multiply and one add per matrix.
    always_comb begin
        off_c = OFF_W'(MUL_W'(idx_i) * MUL_W'(n_cols)  + MUL_W'(idx_j));
        off_a = OFF_W'(MUL_W'(idx_i) * MUL_W'(n_inner) + MUL_W'(idx_v));
        off_b = OFF_W'(MUL_W'(idx_v) * MUL_W'(n_cols)  + MUL_W'(idx_j));
    end

endmodule

// File: rtl/mm_idx_sched.sv
// Nested-loop matrix index scheduler. Walks i, v, j in a selectable nesting
// with per-dimension reversal and presents one offset triple per step.
// Assumes the host holds step low while it cannot accept a triple.
module mm_idx_sched
    import mm_sched_pkg::*;
#(
    parameter  int MAX_STEPS = 127,
    localparam int DIM_W     = $clog2(MAX_STEPS + 1),
    localparam int OFF_W     = DIM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic [DIM_W-1:0] cfg_rows,
    input  logic [DIM_W-1:0] cfg_inner,
    input  logic [DIM_W-1:0] cfg_cols,
    input  logic [2:0]       cfg_order,
    input  logic [2:0]       cfg_rev,
    output logic             valid,
    output logic [OFF_W-1:0] off_c,
    output logic [OFF_W-1:0] off_a,
    output logic [OFF_W-1:0] off_b,
    output logic             done,
    output logic             cfg_err
);
    sched_state_t     state;
    logic [5:0]       rank_q;
    logic             cfg_ok;
    logic             accept;
    logic             fire;
    logic             last_all;
    logic [DIM_W-1:0] cfg_ext [NDIM];
    logic [DIM_W-1:0] cnt     [NDIM];
    logic [DIM_W-1:0] ext_q   [NDIM];
    logic [NDIM-1:0]  at_last;
    logic [NDIM-1:0]  adv;

    // Gather configured extents by dimension index.
    always_comb begin
        cfg_ext[0] = cfg_rows;
        cfg_ext[1] = cfg_inner;
        cfg_ext[2] = cfg_cols;
    end

    mm_cfg_check #(.MAX_STEPS(MAX_STEPS), .DIM_W(DIM_W)) u_check (
        .ext_i  (cfg_rows),
        .ext_v  (cfg_inner),
        .ext_j  (cfg_cols),
        .order  (cfg_order),
        .cfg_ok (cfg_ok)
    );

    // Start handshake and step qualification.
    always_comb begin
        accept   = (state == ST_IDLE) && start && cfg_ok;
        fire     = (state == ST_RUN) && step;
        last_all = &at_last;
    end

    // A dimension advances when every more-inner dimension is at its end.
    always_comb begin
        for (int d = 0; d < NDIM; d++) begin
            logic carry;
            carry = fire;
            for (int e = 0; e < NDIM; e++) begin
                if (rank_q[2*e +: 2] > rank_q[2*d +: 2])
                    carry = carry & at_last[e];
            end
            adv[d] = carry;
        end
    end

    for (genvar g = 0; g < NDIM; g++) begin : g_dim
        mm_dim_counter #(.DIM_W(DIM_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (accept),
            .adv       (adv[g]),
            .extent_in (cfg_ext[g]),
            .rev_in    (cfg_rev[g]),
            .cnt       (cnt[g]),
            .extent_q  (ext_q[g]),
            .at_last   (at_last[g])
        );
    end

    mm_offset_gen #(.DIM_W(DIM_W), .OFF_W(OFF_W)) u_off (
        .idx_i   (cnt[0]),
        .idx_v   (cnt[1]),
        .idx_j   (cnt[2]),
        .n_inner (ext_q[1]),
        .n_cols  (ext_q[2]),
        .off_c   (off_c),
        .off_a   (off_a),
        .off_b   (off_b)
    );

    // Schedule state machine, nesting rank and refusal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rank_q  <= order_rank(3'd0);
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= (state == ST_IDLE) && start && !cfg_ok;
            case (state)
                ST_IDLE: if (accept) begin
                    state  <= ST_RUN;
                    rank_q <= order_rank(cfg_order);
                end
                ST_RUN:  if (fire && last_all) state <= ST_FIN;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output flags decoded from state.
    always_comb begin
        valid = (state == ST_RUN);
        done  = (state == ST_FIN);
    end

endmodule

// File: rtl/mm_idx_sched_chk.sv
// Property checker for the matrix index scheduler, attached by bind.
// Assumes it observes the latched extents of the running schedule.
module mm_idx_sched_chk #(
    parameter int DIM_W = 7,
    parameter int OFF_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             step,
    input logic             valid,
    input logic             done,
    input logic             cfg_err,
    input logic [OFF_W-1:0] off_c,
    input logic [OFF_W-1:0] off_a,
    input logic [OFF_W-1:0] off_b,
    input logic [DIM_W-1:0] ext_i,
    input logic [DIM_W-1:0] ext_v,
    input logic [DIM_W-1:0] ext_j
);
    localparam int MUL_W = 2 * DIM_W;

    logic [MUL_W-1:0] lim_c, lim_a, lim_b;

    // Element counts of each matrix for bound checks.
    always_comb begin
        lim_c = MUL_W'(ext_i) * MUL_W'(ext_j);
        lim_a = MUL_W'(ext_i) * MUL_W'(ext_v);
        lim_b = MUL_W'(ext_v) * MUL_W'(ext_j);
    end

    // R1: every presented offset lies inside its matrix.
    a_r1_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (MUL_W'(off_c) < lim_c) && (MUL_W'(off_a) < lim_a)
               && (MUL_W'(off_b) < lim_b));

    // R8: a triple not consumed is held.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !step |=> valid && $stable(off_c) && $stable(off_a) && $stable(off_b));

    // R9: a start while running neither ends nor refuses the schedule.
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        valid && start && !step |=> valid && !cfg_err);

    // R7: done is a single pulse, follows a consumed triple, and leads to idle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !valid);
    a_r7_done_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(valid && step));
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && done));

    // R6: a refusal starts nothing and lasts one cycle.
    a_r6_refusal: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !valid && !done);
    a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !cfg_err && !valid);

endmodule

bind mm_idx_sched mm_idx_sched_chk #(.DIM_W(DIM_W), .OFF_W(OFF_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .step    (step),
    .valid   (valid),
    .done    (done),
    .cfg_err (cfg_err),
    .off_c   (off_c),
    .off_a   (off_a),
    .off_b   (off_b),
    .ext_i   (ext_q[0]),
    .ext_v   (ext_q[1]),
    .ext_j   (ext_q[2])
);

// File: tb/mm_idx_sched_tb.sv
module mm_idx_sched_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       step = 1'b0;
    logic [6:0] cfg_rows = 7'd1, cfg_inner = 7'd1, cfg_cols = 7'd1;
    logic [2:0] cfg_order = 3'd0, cfg_rev = 3'd0;
    logic       valid, done, cfg_err;
    logic [6:0] off_c, off_a, off_b;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mm_idx_sched u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .step(step),
        .cfg_rows(cfg_rows), .cfg_inner(cfg_inner), .cfg_cols(cfg_cols),
        .cfg_order(cfg_order), .cfg_rev(cfg_rev),
        .valid(valid), .off_c(off_c), .off_a(off_a), .off_b(off_b),
        .done(done), .cfg_err(cfg_err)
    );

    // {rows, inner, cols, order, rev}
    localparam int NVEC = 9;
    localparam logic [26:0] VECS [NVEC] = '{
        {7'd3,   7'd5,   7'd4, 3'd0, 3'b000},
        {7'd2,   7'd3,   7'd2, 3'd1, 3'b000},
        {7'd3,   7'd2,   7'd4, 3'd2, 3'b101},
        {7'd4,   7'd3,   7'd2, 3'd3, 3'b010},
        {7'd2,   7'd2,   7'd3, 3'd4, 3'b111},
        {7'd3,   7'd4,   7'd2, 3'd5, 3'b001},
        {7'd1,   7'd1,   7'd1, 3'd0, 3'b000},
        {7'd127, 7'd1,   7'd1, 3'd0, 3'b001},
        {7'd1,   7'd127, 7'd1, 3'd5, 3'b010}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Dimension at a nesting level (0 outer .. 2 inner) per the R3 table.
    function automatic int dim_at(input int code, input int level);
        int tbl [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};
        return tbl[code][level];
    endfunction

    function automatic int pack3(input int c, input int a, input int b);
        return (c << 16) | (a << 8) | b;
    endfunction

    task automatic run_sched(input int rows, input int inner, input int cols,
                             input int code, input logic [2:0] rev,
                             input bit stall, input bit poke);
        int ext [3];
        int total, prev_c;
        ext[0] = rows; ext[1] = inner; ext[2] = cols;
        total = rows * inner * cols;
        prev_c = -1;
        cfg_rows = 7'(rows); cfg_inner = 7'(inner); cfg_cols = 7'(cols);
        cfg_order = 3'(code); cfg_rev = rev;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        for (int n = 0; n < total; n++) begin
            int x [3];
            int din, dmid, dout, ec, ea, eb, act;
            din = dim_at(code, 2); dmid = dim_at(code, 1); dout = dim_at(code, 0);
            x[din]  = n % ext[din];
            x[dmid] = (n / ext[din]) % ext[dmid];
            x[dout] = n / (ext[din] * ext[dmid]);
            for (int d = 0; d < 3; d++) if (rev[d]) x[d] = ext[d] - 1 - x[d];
            ec = x[0] * cols + x[2];
            ea = x[0] * inner + x[1];
            eb = x[1] * cols + x[2];
            act = pack3(off_c, off_a, off_b);
            // R1 offsets, R3 nesting, R4 reversal, R5 extents, R7 valid after start
            check(valid && act == pack3(ec, ea, eb), "R1 R3 R4 R5 R7 triple",
                  valid ? act : -1, pack3(ec, ea, eb));
            if (code == 0 && cols > 1 && n > 0)
                check(int'(off_c) != prev_c, "R2 accumulator changes", off_c, -1);
            prev_c = off_c;
            if (stall && (n % 3 == 1)) begin
                @(negedge clk);
                check(valid && pack3(off_c, off_a, off_b) == act, "R8 hold on stall",
                      pack3(off_c, off_a, off_b), act);
            end
            if (poke && n == 1) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check(valid && !cfg_err && pack3(off_c, off_a, off_b) == act,
                      "R9 start ignored", pack3(off_c, off_a, off_b), act);
            end
            step = 1'b1;
            @(negedge clk);
            step = 1'b0;
        end
        check(done && !valid, "R5 R7 done after last step", {done, valid}, 2);
        @(negedge clk);
        check(!done && !valid, "R7 single done pulse", {done, valid}, 0);
    endtask

    task automatic bad_cfg(input int rows, input int inner, input int cols, input int code);
        cfg_rows = 7'(rows); cfg_inner = 7'(inner); cfg_cols = 7'(cols);
        cfg_order = 3'(code); cfg_rev = 3'b000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cfg_err && !valid, "R6 refusal", {cfg_err, valid}, 2);
        @(negedge clk);
        check(!cfg_err && !valid && !done, "R6 refusal one cycle", {cfg_err, valid, done}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!valid && !done && !cfg_err, "R10 reset state", {valid, done, cfg_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            run_sched(int'(VECS[k][26:20]), int'(VECS[k][19:13]), int'(VECS[k][12:6]),
                      int'(VECS[k][5:3]), VECS[k][2:0], k < 3, k == 0);
        end

        bad_cfg(8, 4, 4, 0);     // 128 steps
        bad_cfg(0, 3, 3, 0);     // empty
        bad_cfg(2, 2, 2, 6);     // undefined order
        bad_cfg(2, 2, 2, 7);
        run_sched(2, 2, 2, 0, 3'b000, 1'b0, 1'b0);  // recovery after refusal

        // R10: reset mid-schedule returns to idle
        cfg_rows = 7'd4; cfg_inner = 7'd4; cfg_cols = 7'd4; cfg_order = 3'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(!valid && !done && !cfg_err, "R10 reset mid-run", {valid, done, cfg_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule